// File: doc/BRIEF.md
# Data-Cache Maintenance Sequencer

This block sits between a processor's auxiliary-register bus and a first-level data cache. Software writes maintenance commands into it: discard or write back one line by address, or sweep the whole cache. The block turns each command into one or more requests to the cache array. Each request names a set and says whether the line is to be written back, discarded, or both. The cache answers every request with an acknowledge, and while a request is outstanding it reports whether the addressed line is dirty.

The control register holds three things: a disable bit, a mode bit that decides whether an invalidate first writes back dirty data, and a read-only busy flag that stays up while a dirty line is being written back. Software may issue a range operation as a burst of back-to-back single-line writes. Commands are buffered in a two-entry queue and run in the order they were written. When the queue is full, the register port holds off the writer.

Top module: `dc_maint_ctrl`

## Requirements
- R1: After reset the control register reads 0x40, meaning the cache is enabled and the mode bit is 1. No request is active and `reg_ready` is 1.
- R2: A write to the control register (`reg_sel`=0) loads the disable bit from data bit 0 and the mode bit from data bit 6. All other read bits are 0, except bit 8, which ignores writes.
- R3: A single-line invalidate (`reg_sel`=3) issues a request with `op_inv`=1. When the mode bit is 1 the request also has `op_wb`=1. When the mode bit is 0 it has `op_wb`=0, so dirty data is discarded.
- R4: A single-line flush (`reg_sel`=4) issues a request with `op_wb`=1 and `op_inv`=0, so the line stays valid.
- R5: A single-line command issues exactly one request. Its set is address bits [OFF_W +: IDX_W], where OFF_W = log2(LINE_BYTES) and IDX_W = log2(SETS). The offset bits below OFF_W are ignored.
- R6: A whole-cache command (`reg_sel`=1 invalidate, `reg_sel`=2 flush) written with data bit 0 = 1 sweeps sets 0 to SETS-1 in ascending order, one request per set. The set advances on each acknowledge. The whole-cache invalidate takes its write-back choice from the mode bit, as in R3. A whole-cache write with data bit 0 = 0 has no effect.
- R7: A command written while the disable bit is 1 is accepted and issues no request.
- R8: Commands run in the order they were written. At most two commands wait in the queue. `reg_ready` is 0 while two are waiting, and a write held there completes once a slot frees.
- R9: Control bit 8 reads 1 exactly while a request with `op_wb`=1 is outstanding and the cache reports that line dirty. Clean lines never raise it.
- R10: A request keeps `op_req`, `op_set`, `op_wb` and `op_inv` stable until the cycle it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 control, 1 invalidate all, 2 flush all, 3 invalidate line, 4 flush line |
| reg_wdata | input | ADDR_W | Write data or physical address |
| reg_ready | output | 1 | The write is taken on this edge when 1 |
| reg_rdata | output | ADDR_W | Control word when `reg_sel`=0, otherwise 0 |
| op_req | output | 1 | Cache request active |
| op_set | output | IDX_W | Set addressed by the request |
| op_wb | output | 1 | Write back the line if it is dirty |
| op_inv | output | 1 | Discard the line |
| op_ack | input | 1 | Cache has completed the current request |
| op_dirty | input | 1 | Addressed line is dirty (valid while `op_req`) |

## Verification
A register write that is taken on edge k queues its command at that edge. The request is raised after edge k+1, or later if older work is still running. A sweep moves to the next set one edge after each acknowledge, and the busy flag follows `op_dirty` in the same cycle with no register in between. Writes to the control register show up in the read data right after the edge that takes them. The bench applies the same edge rules in a behavioural model built on queues. It compares the model with every output 1 ns after each rising edge, and drives inputs and acknowledges only on falling edges, so every comparison sees settled values. The end of each phase is also checked against a cache stub, by counting requests, write-backs and discarded dirty lines.

// File: rtl/dc_maint_ctrl.sv
module dc_maint_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int SETS       = 16,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int IDX_W     = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic              reg_ready,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              op_req,
  output logic [IDX_W-1:0]  op_set,
  output logic              op_wb,
  output logic              op_inv,
  input  logic              op_ack,
  input  logic              op_dirty
);

  localparam logic [2:0] SEL_CTRL       = 3'd0;
  localparam logic [2:0] SEL_INV_ALL    = 3'd1;
  localparam logic [2:0] SEL_FLUSH_ALL  = 3'd2;
  localparam logic [2:0] SEL_INV_LINE   = 3'd3;
  localparam logic [2:0] SEL_FLUSH_LINE = 3'd4;
  localparam int EW = IDX_W + 3;
  localparam logic [IDX_W-1:0] LAST_SET = IDX_W'(SETS - 1);

  logic          dis_q, imode_q;
  logic [EW-1:0] slot [2];
  logic          wp, rp;
  logic [1:0]    cnt;
  logic          act_q, cur_all, cur_wb, cur_inv;
  logic [IDX_W-1:0] cur_set;

  logic          cmd_ok, e_all, e_wb, e_inv;
  logic [EW-1:0] ent;
  logic          wr_ok, push, pop, busy_flag;

  assign reg_ready = (cnt != 2'd2);
  assign wr_ok     = reg_wr && reg_ready;
  assign push      = wr_ok && cmd_ok && !dis_q;
  assign pop       = !act_q && (cnt != 2'd0);

  always_comb begin
    cmd_ok = 1'b0;
    e_all  = 1'b0;
    e_wb   = 1'b0;
    e_inv  = 1'b0;
    case (reg_sel)
      SEL_INV_ALL:    begin cmd_ok = reg_wdata[0]; e_all = 1'b1; e_inv = 1'b1; e_wb = imode_q; end
      SEL_FLUSH_ALL:  begin cmd_ok = reg_wdata[0]; e_all = 1'b1; e_wb = 1'b1; end
      SEL_INV_LINE:   begin cmd_ok = 1'b1; e_inv = 1'b1; e_wb = imode_q; end
      SEL_FLUSH_LINE: begin cmd_ok = 1'b1; e_wb = 1'b1; end
      default:        cmd_ok = 1'b0;
    endcase
  end

  assign ent = {e_all, e_wb, e_inv, e_all ? '0 : reg_wdata[OFF_W +: IDX_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q   <= 1'b0;
      imode_q <= 1'b1;
    end else if (wr_ok && reg_sel == SEL_CTRL) begin
      dis_q   <= reg_wdata[0];
      imode_q <= reg_wdata[6];
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot[wp] <= ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= 1'b0;
      rp  <= 1'b0;
      cnt <= 2'd0;
    end else begin
      if (push) wp <= ~wp;
      if (pop)  rp <= ~rp;
      cnt <= cnt + 2'(push) - 2'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      cur_all <= 1'b0;
      cur_wb  <= 1'b0;
      cur_inv <= 1'b0;
      cur_set <= '0;
    end else if (pop) begin
      act_q <= 1'b1;
      {cur_all, cur_wb, cur_inv, cur_set} <= slot[rp];
    end else if (act_q && op_ack) begin
      if (cur_all && cur_set != LAST_SET) cur_set <= cur_set + 1'b1;
      else act_q <= 1'b0;
    end
  end

  assign op_req    = act_q;
  assign op_set    = cur_set;
  assign op_wb     = cur_wb;
  assign op_inv    = cur_inv;
  assign busy_flag = act_q && cur_wb && op_dirty;

  always_comb begin
    reg_rdata = '0;
    if (reg_sel == SEL_CTRL) begin
      reg_rdata[0] = dis_q;
      reg_rdata[6] = imode_q;
      reg_rdata[8] = busy_flag;
    end
  end

  assert_hold_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req && !op_ack) |=> (op_req && $stable(op_set) && $stable(op_wb) && $stable(op_inv)));

  assert_kind_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req && !op_wb) |-> op_inv);

  assert_issue_from_queue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_req) |-> $past(cnt != 2'd0));

  assert_sweep_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req && op_ack && cur_all && op_set != LAST_SET) |=> (op_req && op_set == $past(op_set) + 1'b1));

  assert_single_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req && op_ack && !cur_all) |=> !op_req);

endmodule

// File: tb/dc_maint_ctrl_tb.sv
`timescale 1ns/1ps
module dc_maint_ctrl_tb;
  localparam int SETS = 16;
  localparam int IW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_sel = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic reg_ready;
  logic [31:0] reg_rdata;
  logic op_req, op_wb, op_inv;
  logic [IW-1:0] op_set;
  logic op_ack = 1'b0;
  logic op_dirty;

  always #2 clk = ~clk;

  dc_maint_ctrl #(.ADDR_W(32), .LINE_BYTES(32), .SETS(SETS)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_ready(reg_ready), .reg_rdata(reg_rdata), .op_req(op_req), .op_set(op_set),
    .op_wb(op_wb), .op_inv(op_inv), .op_ack(op_ack), .op_dirty(op_dirty));

  int checks = 0, failures = 0;
  string tag = "R1";

  task automatic chk(input bit ok, input string t, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  // cache stub
  bit sdirty [SETS];
  bit svalid [SETS];
  int n_ack = 0, n_wb = 0, n_lost = 0, lat = 1, wcnt = 0;
  int a_set; bit a_wb, a_inv;
  assign op_dirty = op_req && sdirty[op_set];

  always @(negedge clk) begin
    if (op_ack) begin
      n_ack++;
      if (sdirty[a_set] && a_wb) n_wb++;
      if (sdirty[a_set] && !a_wb && a_inv) n_lost++;
      if (a_wb || a_inv) sdirty[a_set] = 1'b0;
      if (a_inv) svalid[a_set] = 1'b0;
    end
    if (rst_n && op_req) begin
      if (wcnt >= lat) begin
        op_ack <= 1'b1; wcnt = 0;
        a_set = int'(op_set); a_wb = op_wb; a_inv = op_inv;
      end else begin
        op_ack <= 1'b0; wcnt++;
      end
    end else begin
      op_ack <= 1'b0; wcnt = 0;
    end
  end

  // behavioural reference model
  logic [15:0] q [$];
  bit m_act, m_all, m_wb, m_inv, m_dis, m_imode;
  int m_set;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_act = 0; m_all = 0; m_wb = 0; m_inv = 0; m_set = 0;
      m_dis = 0; m_imode = 1;
    end else begin
      bit rdy, load;
      logic [15:0] e;
      rdy  = q.size() < 2;
      load = !m_act && q.size() > 0;
      if (m_act && op_ack) begin
        if (m_all && m_set != SETS - 1) m_set++;
        else m_act = 0;
      end
      if (load) begin
        e = q.pop_front();
        m_act = 1; m_all = e[15]; m_wb = e[14]; m_inv = e[13]; m_set = int'(e[7:0]);
      end
      if (reg_wr && rdy) begin
        e = '0;
        case (reg_sel)
          3'd0: begin m_dis = reg_wdata[0]; m_imode = reg_wdata[6]; end
          3'd1: if (reg_wdata[0] && !m_dis) begin e[15] = 1; e[14] = m_imode; e[13] = 1; q.push_back(e); end
          3'd2: if (reg_wdata[0] && !m_dis) begin e[15] = 1; e[14] = 1; q.push_back(e); end
          3'd3: if (!m_dis) begin e[14] = m_imode; e[13] = 1; e[7:0] = 8'((reg_wdata >> 5) % SETS); q.push_back(e); end
          3'd4: if (!m_dis) begin e[14] = 1; e[7:0] = 8'((reg_wdata >> 5) % SETS); q.push_back(e); end
          default: ;
        endcase
      end
    end
  end

  int stat_seen = 0;
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      longint ectl;
      bit st;
      st = m_act && m_wb && sdirty[m_set];
      ectl = (reg_sel == 3'd0) ? ((longint'(st) << 8) | (longint'(m_imode) << 6) | longint'(m_dis)) : 0;
      if (reg_sel == 3'd0 && reg_rdata[8]) stat_seen++;
      chk(op_req === m_act, tag, "op_req", op_req, m_act);
      if (m_act) begin
        chk(int'(op_set) == m_set, "R5", "op_set", op_set, m_set);
        chk(op_wb === m_wb && op_inv === m_inv, tag, "op_wb/op_inv", {op_wb, op_inv}, {m_wb, m_inv});
      end
      chk(reg_ready === (q.size() < 2), "R8", "reg_ready", reg_ready, q.size() < 2);
      chk(reg_rdata == ectl, "R9", "reg_rdata", reg_rdata, ectl);
    end
  end

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    bit ok;
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    do begin ok = reg_ready; @(negedge clk); end while (!ok);
    reg_wr = 1'b0; reg_sel = 3'd0;
  endtask

  task automatic idle();
    repeat (3) @(negedge clk);
    while (m_act || q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int a0, w0, l0;
    for (int i = 0; i < SETS; i++) begin sdirty[i] = (i % 2 == 0); svalid[i] = 1'b1; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(reg_rdata == 32'h40, "R1", "reset ctrl", reg_rdata, 32'h40);
    chk(reg_ready === 1'b1 && op_req === 1'b0, "R1", "reset ready/req", {reg_ready, op_req}, 2'b10);

    tag = "R2";
    wr(3'd0, 32'hFFFF_FFFF);
    chk(reg_rdata == 32'h41, "R2", "ctrl all ones", reg_rdata, 32'h41);
    wr(3'd0, 32'h40);
    chk(reg_rdata == 32'h40, "R2", "ctrl restore", reg_rdata, 32'h40);

    tag = "R4"; lat = 2;
    a0 = n_ack; w0 = n_wb; stat_seen = 0;
    wr(3'd4, 32'h1000); wr(3'd4, 32'h1020); wr(3'd4, 32'h1047); wr(3'd4, 32'h1060);
    idle();
    chk(n_ack - a0 == 4, "R5", "line requests", n_ack - a0, 4);
    chk(n_wb - w0 == 2, "R4", "flush writebacks", n_wb - w0, 2);
    chk(svalid[0] && svalid[2] && !sdirty[0] && !sdirty[2], "R4", "flush keeps valid", {svalid[2], sdirty[2]}, 2'b10);
    chk(stat_seen > 0, "R9", "busy seen on dirty flush", stat_seen, 1);

    tag = "R3";
    w0 = n_wb;
    wr(3'd3, 32'h1080);
    idle();
    chk(n_wb - w0 == 1 && !svalid[4], "R3", "inv mode1 writes back", n_wb - w0, 1);
    wr(3'd0, 32'h0);
    w0 = n_wb; l0 = n_lost;
    wr(3'd3, 32'h10C5);
    idle();
    chk(n_lost - l0 == 1 && n_wb == w0, "R3", "inv mode0 discards", n_lost - l0, 1);
    chk(!svalid[6], "R3", "inv mode0 line gone", svalid[6], 0);
    wr(3'd0, 32'h40);

    tag = "R6"; lat = 1;
    a0 = n_ack; w0 = n_wb;
    wr(3'd2, 32'h1);
    idle();
    chk(n_ack - a0 == SETS, "R6", "sweep requests", n_ack - a0, SETS);
    chk(n_wb - w0 == 4, "R6", "sweep writebacks", n_wb - w0, 4);
    a0 = n_ack;
    wr(3'd2, 32'h0); wr(3'd1, 32'h0);
    idle();
    chk(n_ack == a0, "R6", "data bit0 clear ignored", n_ack - a0, 0);
    stat_seen = 0;
    wr(3'd2, 32'h1);
    idle();
    chk(stat_seen == 0, "R9", "clean sweep no busy", stat_seen, 0);

    tag = "R7";
    wr(3'd0, 32'h41);
    a0 = n_ack;
    wr(3'd4, 32'h2000); wr(3'd1, 32'h1); wr(3'd3, 32'h2040);
    idle();
    chk(n_ack == a0, "R7", "disabled no requests", n_ack - a0, 0);
    chk(reg_rdata == 32'h41, "R7", "disabled ctrl", reg_rdata, 32'h41);
    wr(3'd0, 32'h40);

    tag = "R8"; lat = 0;
    sdirty[1] = 1; sdirty[9] = 1; sdirty[15] = 1;
    a0 = n_ack; w0 = n_wb;
    wr(3'd1, 32'h1); wr(3'd4, 32'h1020); wr(3'd3, 32'h1120);
    idle();
    chk(n_ack - a0 == SETS + 2, "R8", "queued commands all run", n_ack - a0, SETS + 2);
    chk(n_wb - w0 == 3, "R3", "inv all writebacks", n_wb - w0, 3);
    chk(!svalid[0] && !svalid[15], "R6", "inv all clears", {svalid[0], svalid[15]}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule